// File: doc/BRIEF.md
# Keyed-Reset Sensor Register Front-End

This block is the 32-bit memory-mapped register slave of a sensor-style peripheral. It takes single-beat requests over a valid/ready channel that carries byte enables. Each request gets a registered response one cycle later, which returns read data and an error flag. Word-aligned offsets select one of five kinds of location: a write-only reset key, a toggle-on-write register, a bank of read/write configuration registers, a bank of read-only 16-bit sample words, and everything else, which reads as zero and ignores writes.

Writing the exact key value to the reset location produces a soft reset pulse of fixed length. The pulse returns the configuration and toggle registers to their defaults, and it is also driven out to reset the converter stand-in. While the pulse is high the slave holds `req_ready_o` low. The sample words come from the sensor model on a packed input vector. They appear in the low half of the bus word, and the upper half reads as zero.

Top module: `sensreg_front`

## Requirements
- R1: An accepted full-word write of KEY (default 32'h0000_000A) to offset 0x000 drives `soft_rst_o` high in the two cycles that follow the accepting edge, and low after that.
- R2: A full-word write of any other value to offset 0x000 produces no pulse and returns `resp_err_o`=0. A read of 0x000 returns 0.
- R3: A request whose `req_be_i` is not 4'b1111 returns `resp_err_o`=1 and `resp_rdata_o`=0. It changes no register, and it raises no pulse even when it carries the key.
- R4: Sample word i is read at offset 0x200+4*i as {16'h0, sens_data_i[16*i+15:16*i]}. A write there changes nothing.
- R5: For the toggle register at offset 0x004, a full-word write inverts every bit whose write-data bit is 1 and keeps every bit whose write-data bit is 0. A read returns the current value.
- R6: Configuration register i at offset 0x010+4*i returns the last full-word value written to it. Its default is CFG_RST (default 32'h0000_00A5).
- R7: Every other offset, including 0x360 to 0x3FC, ignores writes and reads as 0. Neither access raises an error.
- R8: While `soft_rst_o` is high, `req_ready_o` is low. After the pulse, the configuration registers read CFG_RST and the toggle register reads TOG_RST (default 0).
- R9: Every accepted request gets exactly one response, with `resp_valid_o` high in the cycle after the accepting edge. `resp_valid_o` is low in every other cycle.
- R10: After `rst_ni` is released, `soft_rst_o`=0, `req_ready_o`=1, `resp_valid_o`=0, and the registers hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Slave can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (10) | Byte offset |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte enables; only 4'b1111 is a legal access |
| sens_data_i | input | 16*NUM_SENS (128) | Sample words from the converter stand-in |
| resp_valid_o | output | 1 | Response present |
| resp_rdata_o | output | 32 | Read data, 0 for writes and errors |
| resp_err_o | output | 1 | Sub-word access error |
| soft_rst_o | output | 1 | Soft reset pulse |

## Verification
Two events can land in the same cycle: the response to a key write and the first cycle of the reset pulse. A request that arrives in that cycle also has to be held off. The bench provokes this by presenting a read of the toggle register at the first falling edge after the key write is accepted, and by keeping that read valid. The test passes if the key write's response is error-free, if the read stays unaccepted for exactly the two cycles in which `soft_rst_o` is high, and if the read returns the cleared toggle value, not the value set before the key write.

// File: rtl/sensreg_pkg.sv
package sensreg_pkg;

    typedef enum logic [2:0] {
        RG_KEY    = 3'd0,
        RG_TOGGLE = 3'd1,
        RG_CFG    = 3'd2,
        RG_SENSE  = 3'd3,
        RG_VOID   = 3'd4
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [7:0] idx;
    } dec_t;

endpackage

// File: rtl/sensreg_decode.sv
module sensreg_decode
    import sensreg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned NUM_CFG  = 4,
    parameter int unsigned NUM_SENS = 8,
    parameter int unsigned CFG_OFS  = 'h010,
    parameter int unsigned SENS_OFS = 'h200
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int unsigned KEY_W  = 0;
    localparam int unsigned TOG_W  = 1;
    localparam int unsigned CFG_W0 = CFG_OFS / 4;
    localparam int unsigned SNS_W0 = SENS_OFS / 4;

    int unsigned widx;

    always_comb begin
        widx         = 32'(addr_i[ADDR_W-1:2]);
        dec_o.region = RG_VOID;
        dec_o.idx    = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (widx == KEY_W) begin
                dec_o.region = RG_KEY;
            end else if (widx == TOG_W) begin
                dec_o.region = RG_TOGGLE;
            end else if (widx >= CFG_W0 && widx < CFG_W0 + NUM_CFG) begin
                dec_o.region = RG_CFG;
                dec_o.idx    = 8'(widx - CFG_W0);
            end else if (widx >= SNS_W0 && widx < SNS_W0 + NUM_SENS) begin
                dec_o.region = RG_SENSE;
                dec_o.idx    = 8'(widx - SNS_W0);
            end
        end
    end

endmodule

// File: rtl/sensreg_pulse.sv
module sensreg_pulse #(
    parameter logic [31:0] KEY       = 32'h0000_000A,
    parameter int unsigned PULSE_CYC = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        key_wr_i,
    input  logic [31:0] data_i,
    output logic        active_o
);
    localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pstate_t;

    pstate_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (key_wr_i && data_i == KEY) begin
            p_d.cnt = CNT_W'(PULSE_CYC);
        end else if (p_q.cnt != '0) begin
            p_d.cnt = p_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    assign active_o = (p_q.cnt != '0);

endmodule

// File: rtl/sensreg_bank.sv
module sensreg_bank
    import sensreg_pkg::*;
#(
    parameter int unsigned NUM_CFG = 4,
    parameter logic [31:0] CFG_RST = 32'h0000_00A5,
    parameter logic [31:0] TOG_RST = 32'h0000_0000
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     clr_i,
    input  logic                     wr_i,
    input  dec_t                     dec_i,
    input  logic [31:0]              wdata_i,
    output logic [NUM_CFG-1:0][31:0] cfg_o,
    output logic [31:0]              tog_o
);
    typedef struct packed {
        logic [NUM_CFG-1:0][31:0] cfg;
        logic [31:0]              tog;
    } bstate_t;

    bstate_t b_d, b_q;
    bstate_t b_rst;

    always_comb begin
        for (int i = 0; i < NUM_CFG; i++) b_rst.cfg[i] = CFG_RST;
        b_rst.tog = TOG_RST;
    end

    always_comb begin
        b_d = b_q;
        if (clr_i) begin
            b_d = b_rst;
        end else if (wr_i) begin
            case (dec_i.region)
                RG_CFG: begin
                    for (int i = 0; i < NUM_CFG; i++) begin
                        if (dec_i.idx == 8'(i)) b_d.cfg[i] = wdata_i;
                    end
                end
                RG_TOGGLE: b_d.tog = b_q.tog ^ wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) b_q <= b_rst;
        else         b_q <= b_d;
    end

    assign cfg_o = b_q.cfg;
    assign tog_o = b_q.tog;

endmodule

// File: rtl/sensreg_front.sv
module sensreg_front
    import sensreg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned NUM_CFG   = 4,
    parameter int unsigned NUM_SENS  = 8,
    parameter int unsigned PULSE_CYC = 2,
    parameter logic [31:0] KEY       = 32'h0000_000A,
    parameter logic [31:0] CFG_RST   = 32'h0000_00A5,
    parameter logic [31:0] TOG_RST   = 32'h0000_0000
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic                   req_write_i,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic [31:0]            req_wdata_i,
    input  logic [3:0]             req_be_i,
    input  logic [16*NUM_SENS-1:0] sens_data_i,
    output logic                   resp_valid_o,
    output logic [31:0]            resp_rdata_o,
    output logic                   resp_err_o,
    output logic                   soft_rst_o
);
    localparam logic [3:0] BE_FULL = 4'b1111;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] rdata;
    } rsp_t;

    rsp_t r_d, r_q;
    dec_t dec;
    logic accept, full_word, wr_ok, key_wr, pulse_on;
    logic [NUM_CFG-1:0][31:0] cfg;
    logic [31:0] tog, rd_mux;

    sensreg_decode #(
        .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .NUM_SENS(NUM_SENS)
    ) u_dec (
        .addr_i(req_addr_i),
        .dec_o (dec)
    );

    assign accept    = req_valid_i && req_ready_o;
    assign full_word = (req_be_i == BE_FULL);
    assign wr_ok     = accept && req_write_i && full_word;
    assign key_wr    = wr_ok && (dec.region == RG_KEY);

    sensreg_pulse #(
        .KEY(KEY), .PULSE_CYC(PULSE_CYC)
    ) u_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .key_wr_i(key_wr),
        .data_i  (req_wdata_i),
        .active_o(pulse_on)
    );

    sensreg_bank #(
        .NUM_CFG(NUM_CFG), .CFG_RST(CFG_RST), .TOG_RST(TOG_RST)
    ) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (pulse_on),
        .wr_i   (wr_ok),
        .dec_i  (dec),
        .wdata_i(req_wdata_i),
        .cfg_o  (cfg),
        .tog_o  (tog)
    );

    always_comb begin
        rd_mux = '0;
        case (dec.region)
            RG_TOGGLE: rd_mux = tog;
            RG_CFG: begin
                for (int i = 0; i < NUM_CFG; i++) begin
                    if (dec.idx == 8'(i)) rd_mux = cfg[i];
                end
            end
            RG_SENSE: begin
                for (int i = 0; i < NUM_SENS; i++) begin
                    if (dec.idx == 8'(i)) rd_mux = {16'h0000, sens_data_i[16*i +: 16]};
                end
            end
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        r_d       = '0;
        r_d.valid = accept;
        r_d.err   = accept && !full_word;
        if (accept && !req_write_i && full_word) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign req_ready_o  = !pulse_on;
    assign soft_rst_o   = pulse_on;
    assign resp_valid_o = r_q.valid;
    assign resp_err_o   = r_q.err;
    assign resp_rdata_o = r_q.rdata;

endmodule

// File: rtl/sensreg_front_chk.sv
module sensreg_front_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter logic [31:0] KEY    = 32'h0000_000A
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [31:0]       req_wdata_i,
    input logic [3:0]        req_be_i,
    input logic              resp_valid_o,
    input logic [31:0]       resp_rdata_o,
    input logic              resp_err_o,
    input logic              soft_rst_o
);
    logic acc, full, key_acc, void_rd, sense_rd;

    assign acc      = req_valid_i && req_ready_o;
    assign full     = (req_be_i == 4'b1111);
    assign key_acc  = acc && req_write_i && full && req_addr_i == '0 && req_wdata_i == KEY;
    assign void_rd  = acc && !req_write_i && full && req_addr_i >= ADDR_W'('h360);
    assign sense_rd = acc && !req_write_i && req_addr_i >= ADDR_W'('h200)
                      && req_addr_i < ADDR_W'('h220);

    AST_KEY_STARTS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_acc |=> $rose(soft_rst_o)); // R1
    AST_PULSE_SECOND_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(soft_rst_o) |=> soft_rst_o); // R1
    AST_PULSE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (soft_rst_o && $past(soft_rst_o)) |=> !soft_rst_o); // R1
    AST_PULSE_ONLY_FROM_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(soft_rst_o) |-> $past(key_acc)); // R2
    AST_SUBWORD_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> resp_err_o == ($past(req_be_i) != 4'b1111)); // R3
    AST_SENSE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sense_rd |=> resp_rdata_o[31:16] == 16'h0000); // R4
    AST_VOID_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        void_rd |=> (resp_rdata_o == '0 && !resp_err_o)); // R7
    AST_NO_READY_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_o |-> !req_ready_o); // R8
    AST_RESP_FOLLOWS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> resp_valid_o); // R9
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc |=> !resp_valid_o); // R9

endmodule

bind sensreg_front sensreg_front_chk #(.ADDR_W(ADDR_W), .KEY(KEY)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_be_i    (req_be_i),
    .resp_valid_o(resp_valid_o),
    .resp_rdata_o(resp_rdata_o),
    .resp_err_o  (resp_err_o),
    .soft_rst_o  (soft_rst_o)
);

// File: tb/sensreg_front_tb.sv
module sensreg_front_tb;
    localparam int NUM_SENS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic [16*NUM_SENS-1:0] sens;
    logic        req_ready, resp_valid, resp_err, soft_rst;
    logic [31:0] resp_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    initial begin
        for (int i = 0; i < NUM_SENS; i++) sens[16*i +: 16] = 16'h8000 | 16'(i * 'h0123);
    end

    sensreg_front u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
        .sens_data_i(sens),
        .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata), .resp_err_o(resp_err),
        .soft_rst_o(soft_rst)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [9:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd, output logic er,
                          output logic rv);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rv = resp_valid; rd = resp_rdata; er = resp_err;
    endtask

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h010, 32'h0,          4'hF, 32'h0000_00A5, 1'b0, 4'd10}, // R10
        '{1'b0, 10'h004, 32'h0,          4'hF, 32'h0000_0000, 1'b0, 4'd10}, // R10
        '{1'b1, 10'h010, 32'h1234_5678,  4'hF, 32'h0,         1'b0, 4'd6},  // R6
        '{1'b0, 10'h010, 32'h0,          4'hF, 32'h1234_5678, 1'b0, 4'd6},  // R6
        '{1'b1, 10'h01C, 32'hDEAD_BEEF,  4'hF, 32'h0,         1'b0, 4'd6},  // R6
        '{1'b0, 10'h01C, 32'h0,          4'hF, 32'hDEAD_BEEF, 1'b0, 4'd6},  // R6
        '{1'b0, 10'h014, 32'h0,          4'hF, 32'h0000_00A5, 1'b0, 4'd6},  // R6
        '{1'b1, 10'h004, 32'h0000_00F0,  4'hF, 32'h0,         1'b0, 4'd5},  // R5
        '{1'b0, 10'h004, 32'h0,          4'hF, 32'h0000_00F0, 1'b0, 4'd5},  // R5
        '{1'b1, 10'h004, 32'h0000_0FF0,  4'hF, 32'h0,         1'b0, 4'd5},  // R5
        '{1'b0, 10'h004, 32'h0,          4'hF, 32'h0000_0F00, 1'b0, 4'd5},  // R5
        '{1'b1, 10'h004, 32'h0,          4'hF, 32'h0,         1'b0, 4'd5},  // R5
        '{1'b0, 10'h004, 32'h0,          4'hF, 32'h0000_0F00, 1'b0, 4'd5},  // R5
        '{1'b0, 10'h20C, 32'h0,          4'hF, 32'h0000_8369, 1'b0, 4'd4},  // R4
        '{1'b1, 10'h20C, 32'hFFFF_FFFF,  4'hF, 32'h0,         1'b0, 4'd4},  // R4
        '{1'b0, 10'h20C, 32'h0,          4'hF, 32'h0000_8369, 1'b0, 4'd4},  // R4
        '{1'b0, 10'h21C, 32'h0,          4'hF, 32'h0000_87F5, 1'b0, 4'd4},  // R4
        '{1'b1, 10'h010, 32'h0,          4'h3, 32'h0,         1'b1, 4'd3},  // R3
        '{1'b0, 10'h010, 32'h0,          4'h1, 32'h0,         1'b1, 4'd3},  // R3
        '{1'b0, 10'h010, 32'h0,          4'hF, 32'h1234_5678, 1'b0, 4'd3},  // R3
        '{1'b1, 10'h380, 32'h0000_0055,  4'hF, 32'h0,         1'b0, 4'd7},  // R7
        '{1'b0, 10'h380, 32'h0,          4'hF, 32'h0,         1'b0, 4'd7}   // R7
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic er, rv;
        int lowcnt, hicnt;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: state after reset release
        chk(!soft_rst, "R10 soft_rst_o after reset", 32'(soft_rst), 32'd0);
        chk(req_ready, "R10 req_ready_o after reset", 32'(req_ready), 32'd1);
        chk(!resp_valid, "R10 resp_valid_o after reset", 32'(resp_valid), 32'd0);

        foreach (VECS[k]) begin
            bus_op(VECS[k].wr, VECS[k].addr, VECS[k].wdata, VECS[k].be, rd, er, rv);
            tag = $sformatf("R%0d vector %0d", VECS[k].req, k);
            chk(rv, {tag, " resp_valid"}, 32'(rv), 32'd1);
            chk(er == VECS[k].err, {tag, " resp_err"}, 32'(er), 32'(VECS[k].err));
            chk(rd == VECS[k].exp, {tag, " rdata"}, rd, VECS[k].exp);
        end

        // R9: no response on an idle cycle
        @(negedge clk);
        chk(!resp_valid, "R9 resp_valid_o idle", 32'(resp_valid), 32'd0);

        // R2: non-key write and read of key location
        bus_op(1'b1, 10'h000, 32'h0000_000B, 4'hF, rd, er, rv);
        chk(!er, "R2 non-key write error flag", 32'(er), 32'd0);
        hicnt = 0;
        for (int c = 0; c < 4; c++) begin
            if (soft_rst) hicnt++;
            @(negedge clk);
        end
        chk(hicnt == 0, "R2 no pulse after non-key write", 32'(hicnt), 32'd0);
        bus_op(1'b0, 10'h000, 32'h0, 4'hF, rd, er, rv);
        chk(rd == 32'h0 && !er, "R2 read of key location", rd, 32'h0);

        // R3: key value with partial byte enables
        bus_op(1'b1, 10'h000, 32'h0000_000A, 4'h7, rd, er, rv);
        chk(er, "R3 sub-word key write error", 32'(er), 32'd1);
        hicnt = 0;
        for (int c = 0; c < 4; c++) begin
            if (soft_rst) hicnt++;
            @(negedge clk);
        end
        chk(hicnt == 0, "R3 no pulse after sub-word key", 32'(hicnt), 32'd0);

        // toggle register currently 0x0F00, cfg0 0x12345678 before the key
        // R1 / R8: key write with a read held valid behind it
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h000;
        req_wdata = 32'h0000_000A; req_be = 4'hF;
        @(negedge clk);
        chk(resp_valid && !resp_err, "R1 key write response", 32'(resp_err), 32'd0);
        chk(soft_rst, "R1 pulse starts after key accept", 32'(soft_rst), 32'd1);
        req_write = 1'b0; req_addr = 10'h004; req_wdata = '0;
        lowcnt = 0; hicnt = 0;
        while (!req_ready && lowcnt < 10) begin
            lowcnt++;
            if (soft_rst) hicnt++;
            @(negedge clk);
        end
        chk(hicnt == 2, "R1 pulse width in cycles", 32'(hicnt), 32'd2);
        chk(lowcnt == 2, "R8 ready low during pulse", 32'(lowcnt), 32'd2);
        chk(!soft_rst, "R1 pulse ended", 32'(soft_rst), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid, "R9 held read answered", 32'(resp_valid), 32'd1);
        chk(resp_rdata == 32'h0, "R8 toggle cleared by pulse", resp_rdata, 32'h0);
        bus_op(1'b0, 10'h010, 32'h0, 4'hF, rd, er, rv);
        chk(rd == 32'h0000_00A5, "R8 cfg restored by pulse", rd, 32'h0000_00A5);
        bus_op(1'b0, 10'h200, 32'h0, 4'hF, rd, er, rv);
        chk(rd == 32'h0000_8000, "R4 sample word 0 after pulse", rd, 32'h0000_8000);
        bus_op(1'b0, 10'h3FC, 32'h0, 4'hF, rd, er, rv);
        chk(rd == 32'h0 && !er, "R7 top of undefined range", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule